// File: doc/BRIEF.md
# Interrupt Request Gate with Global Mask Layer

This block sits between six interrupt sources and the processor's interrupt input. Four sources are external inputs, one is an interval timer and one is a high-speed counter. Each source raises a one-cycle request pulse. The pulse sets a per-source pending flip-flop. The flag stays set until the matching acknowledge clears it.

Every source has an individual mask bit that software loads as a whole word. A single global mask sits above all the individual masks. A command port sets or clears the global mask. The global mask never rewrites the individual masks. Requests that arrive while any mask blocks them are still recorded as pending. They reach the processor as soon as the masks blocking them are cleared.

Global mask commands are refused while the in-service flag reports that an interrupt routine is running. The combined interrupt line is registered. It is high when at least one pending source is unmasked individually and the global mask is clear.

Top module: `irq_gate_top`

## Requirements
- R1: After reset the global mask is clear, all six individual mask bits read as set (masked), every pending flag is 0 and irq_o is 0.
- R2: A 1 on req_i[i] at a clock edge sets pend_o[i] from that edge onward. The flag stays set, whatever the masks are, until it is acknowledged.
- R3: A 1 on ack_i[i] clears pend_o[i] at that edge. If req_i[i] and ack_i[i] are both 1 at the same edge, pend_o[i] stays set.
- R4: When imask_we_i is 1, the individual masks load imask_wdata_i, where bit i = 1 masks source i. When imask_we_i is 0, the individual masks keep their value.
- R5: irq_o is registered. It goes to 1 one edge after at least one pending source has its individual mask bit at 0 while the global mask is clear, and to 0 one edge after no source meets that condition.
- R6: When gcmd_valid_i is 1, code 2'b01 sets the global mask and code 2'b10 clears it. Codes 2'b00 and 2'b11 change nothing.
- R7: While the global mask is set, irq_o stays 0, and incoming requests are still latched in pend_o.
- R8: When the global mask is cleared, pending unmasked sources drive irq_o to 1 one edge after the clearing edge.
- R9: Setting and then clearing the global mask leaves every individual mask bit at the value it had before.
- R10: While in_service_i is 1, global mask and unmask commands have no effect.
- R11: The global mask applies to all six sources: the four inputs (indices 0 to 3), the timer (index 4) and the counter (index 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 6 | Request pulses, one bit per source |
| ack_i | input | 6 | Acknowledge pulses, one bit per source |
| imask_we_i | input | 1 | Individual mask write enable |
| imask_wdata_i | input | 6 | New individual mask word (1 = masked) |
| gcmd_valid_i | input | 1 | Global mask command strobe |
| gcmd_code_i | input | 2 | Global command code: 01 mask all, 10 unmask all |
| in_service_i | input | 1 | High while an interrupt routine runs |
| pend_o | output | 6 | Per-source pending flags |
| irq_o | output | 1 | Registered combined interrupt request |

## Verification
A lost pending bit shows up on pend_o at the edge after the request or acknowledge. A wrong global mask state shows up on irq_o exactly one edge later, as a missing or spurious interrupt. Damage to an individual mask hides until the global mask is cleared. The bench therefore masks one source individually across a global mask cycle and expects irq_o to fall when only that source is left pending. A command accepted during service shows as irq_o staying low after an ordinary request.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
    localparam int unsigned SRC_NUM = 6;
    localparam int unsigned GCMD_W  = 2;

    typedef enum logic [GCMD_W-1:0] {
        GCMD_NOP    = 2'b00,
        GCMD_MASK   = 2'b01,
        GCMD_UNMASK = 2'b10,
        GCMD_RSVD   = 2'b11
    } gcmd_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] ack_i,
    output logic [N-1:0] pend_o
);
    typedef struct packed {
        logic [N-1:0] pend;
    } pend_st_t;

    pend_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            // a request wins over a same-cycle acknowledge
            st_d.pend[i] = req_i[i] | (st_q.pend[i] & ~ack_i[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    for (genvar g = 0; g < N; g++) begin : g_chk
        p_req_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
            req_i[g] |=> pend_o[g]);
        p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_i[g] && !req_i[g]) |=> !pend_o[g]);
        p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_o[g] && !ack_i[g]) |=> pend_o[g]);
    end
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
    import irq_gate_pkg::*;
#(
    parameter int unsigned N = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              imask_we_i,
    input  logic [N-1:0]      imask_wdata_i,
    input  logic              gcmd_valid_i,
    input  logic [GCMD_W-1:0] gcmd_code_i,
    input  logic              in_service_i,
    output logic [N-1:0]      imask_o,
    output logic              gmask_o
);
    typedef struct packed {
        logic [N-1:0] imask;
        logic         gmask;
    } mask_st_t;

    mask_st_t st_d, st_q;
    logic     cmd_ok;

    assign cmd_ok = gcmd_valid_i & ~in_service_i;

    always_comb begin
        st_d = st_q;
        if (imask_we_i) st_d.imask = imask_wdata_i;
        if (cmd_ok) begin
            case (gcmd_e'(gcmd_code_i))
                GCMD_MASK:   st_d.gmask = 1'b1;
                GCMD_UNMASK: st_d.gmask = 1'b0;
                default:     st_d.gmask = st_q.gmask;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.imask <= '1;
            st_q.gmask <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign imask_o = st_q.imask;
    assign gmask_o = st_q.gmask;

    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_service_i |=> $stable(gmask_o));
    p_mask_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gcmd_valid_i && !in_service_i && gcmd_code_i == 2'b01) |=> gmask_o);
    p_unmask_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gcmd_valid_i && !in_service_i && gcmd_code_i == 2'b10) |=> !gmask_o);
    p_imask_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !imask_we_i |=> $stable(imask_o));
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pend_i,
    input  logic [N-1:0] imask_i,
    input  logic         gmask_i,
    output logic         irq_o
);
    typedef struct packed {
        logic irq;
    } out_st_t;

    out_st_t      st_d, st_q;
    logic [N-1:0] live;

    for (genvar g = 0; g < N; g++) begin : g_live
        assign live[g] = pend_i[g] & ~imask_i[g];
    end

    always_comb begin
        st_d     = st_q;
        st_d.irq = (|live) & ~gmask_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    p_gmask_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gmask_i |=> !irq_o);
    p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i == '0) |=> !irq_o);
endmodule

// File: rtl/irq_gate_top.sv
module irq_gate_top
    import irq_gate_pkg::*;
#(
    parameter int unsigned N = SRC_NUM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      req_i,
    input  logic [N-1:0]      ack_i,
    input  logic              imask_we_i,
    input  logic [N-1:0]      imask_wdata_i,
    input  logic              gcmd_valid_i,
    input  logic [GCMD_W-1:0] gcmd_code_i,
    input  logic              in_service_i,
    output logic [N-1:0]      pend_o,
    output logic              irq_o
);
    logic [N-1:0] imask;
    logic         gmask;

    irq_pend_bank #(.N(N)) pend_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_i(ack_i), .pend_o(pend_o)
    );

    irq_mask_regs #(.N(N)) mask_i (
        .clk(clk), .rst_n(rst_n),
        .imask_we_i(imask_we_i), .imask_wdata_i(imask_wdata_i),
        .gcmd_valid_i(gcmd_valid_i), .gcmd_code_i(gcmd_code_i),
        .in_service_i(in_service_i),
        .imask_o(imask), .gmask_o(gmask)
    );

    irq_out_stage #(.N(N)) out_i (
        .clk(clk), .rst_n(rst_n), .pend_i(pend_o), .imask_i(imask),
        .gmask_i(gmask), .irq_o(irq_o)
    );

    p_irq_needs_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|pend_o));
endmodule

// File: tb/irq_gate_top_tb_top.sv
module irq_gate_top_tb_top;
    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0, ack = '0, imask_wdata = '0;
    logic         imask_we = 1'b0, gcmd_valid = 1'b0, in_service = 1'b0;
    logic [1:0]   gcmd_code = 2'b00;
    logic [N-1:0] pend;
    logic         irq;
    int           n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    irq_gate_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .ack_i(ack),
        .imask_we_i(imask_we), .imask_wdata_i(imask_wdata),
        .gcmd_valid_i(gcmd_valid), .gcmd_code_i(gcmd_code),
        .in_service_i(in_service), .pend_o(pend), .irq_o(irq)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pulse_req(logic [N-1:0] v);
        req = v; tick(); req = '0;
    endtask

    task automatic pulse_ack(logic [N-1:0] v);
        ack = v; tick(); ack = '0;
    endtask

    task automatic write_imask(logic [N-1:0] v);
        imask_we = 1'b1; imask_wdata = v; tick(); imask_we = 1'b0;
    endtask

    task automatic gcmd(logic [1:0] c);
        gcmd_valid = 1'b1; gcmd_code = c; tick(); gcmd_valid = 1'b0;
    endtask

    task automatic clean();
        pulse_ack('1); tick();
    endtask

    task automatic t_reset();
        check("R1 pend after reset", pend, 0);
        check("R1 irq after reset", irq, 0);
        pulse_req(6'h3F); tick();
        check("R1 imask set: pend latched", pend, 6'h3F);
        check("R1 imask set: irq low", irq, 0);
        clean();
        check("R1 cleared", pend, 0);
    endtask

    task automatic t_pend_ack();
        write_imask('0);
        pulse_req(6'h04);
        check("R2 pend set", pend, 6'h04);
        tick();
        check("R5 irq one edge later", irq, 1);
        tick(); tick();
        check("R2 pend holds", pend, 6'h04);
        pulse_ack(6'h04);
        check("R3 ack clears", pend, 0);
        check("R5 irq still high one edge", irq, 1);
        tick();
        check("R5 irq drops", irq, 0);
        req = 6'h08; ack = 6'h08; tick(); req = '0; ack = '0;
        check("R3 req+ack keeps set", pend, 6'h08);
        clean();
    endtask

    task automatic t_imask();
        write_imask(6'h3E);
        pulse_req(6'h02); tick();
        check("R4 masked src1 no irq", irq, 0);
        pulse_req(6'h01); tick();
        check("R4 unmasked src0 irq", irq, 1);
        clean();
        write_imask(6'h00);
    endtask

    task automatic t_global();
        gcmd(2'b01);
        pulse_req(6'h3F); tick();
        check("R7 pend latched while gmask", pend, 6'h3F);
        check("R7 irq low while gmask", irq, 0);
        gcmd(2'b00); gcmd(2'b11); tick();
        check("R6 nop/reserved codes", irq, 0);
        gcmd(2'b10);
        check("R8 irq one edge after clear: not yet", irq, 0);
        tick();
        check("R8 delivered after clear", irq, 1);
        clean();
        for (int i = 0; i < N; i++) begin
            gcmd(2'b01);
            pulse_req(6'(1 << i)); tick(); tick();
            check($sformatf("R11 src%0d blocked", i), irq, 0);
            gcmd(2'b10); tick();
            check($sformatf("R11 src%0d delivered", i), irq, 1);
            clean();
        end
    endtask

    task automatic t_restore();
        write_imask(6'h01);
        gcmd(2'b01);
        pulse_req(6'h03);
        gcmd(2'b10); tick();
        check("R9 irq from src1", irq, 1);
        pulse_ack(6'h02); tick();
        check("R9 src0 still masked", irq, 0);
        check("R9 src0 pending", pend, 6'h01);
        clean();
        write_imask(6'h00);
    endtask

    task automatic t_busy();
        in_service = 1'b1; gcmd(2'b01); in_service = 1'b0;
        pulse_req(6'h02); tick();
        check("R10 mask refused in service", irq, 1);
        clean();
        gcmd(2'b01);
        pulse_req(6'h10);
        in_service = 1'b1; gcmd(2'b10); in_service = 1'b0;
        tick();
        check("R10 unmask refused in service", irq, 0);
        gcmd(2'b10); tick();
        check("R10 unmask after service", irq, 1);
        clean();
    endtask

    initial begin
        #4_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick(); tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_pend_ack();
        t_imask();
        t_global();
        t_restore();
        t_busy();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule